// File: doc/BRIEF.md
# Video Control Register Slave over I2C

This block is the control plane of a picture-improvement video processor. An external host talks to it over a two-wire I2C bus. It holds eleven byte-wide write registers whose values leave the block as one flat vector. It also returns five read-only bytes: a status byte and four measurement bytes supplied by neighbouring logic. SCL and SDA are oversampled by the block clock. SDA is returned as an open-drain pull-low request.

A pin selects between two slave addresses. That pin is copied into two positions of the 7-bit address, giving 40H or E0H as the write byte. A write carries a subaddress followed by any number of data bytes, and the subaddress advances after each byte. A read has no subaddress: it always begins at the status byte and advances through the measurement bytes. Two status flags are sticky and clear when read: one marks a picture change and one marks a supply interruption. A picture change also pulls an active-low indicator pin for the length of the next retrace line.

Top module: `vidctl_i2c_regs`

## Requirements
- R1: The block acknowledges only the address byte whose upper seven bits equal {sel,1,sel,0,0,0,0}, where sel is `addr_sel_i`. That is 40H/41H with sel low and E0H/E1H with sel high. Any other address gets no acknowledge, no register changes, and SDA stays released until the next START.
- R2: After reset every control register reads 00H except register 00H, which reads 01H (bit 0 set), and register 06H, which reads 20H (bit 5 set).
- R3: In a write, the first byte after the address is the subaddress. Each later data byte is acknowledged and stored into the register at the current subaddress, and the subaddress then advances by one. Register n appears on `ctl_flat_o[8n+7:8n]`.
- R4: Data bytes aimed at subaddresses above 0AH are acknowledged but change no register.
- R5: Every read, including one entered through a repeated START after a write, returns the status byte first. It then returns the measurement bytes 1 to 4 taken from `meas_flat_i[8k-1:8k-8]` for k = 1..4. Bytes requested after the fourth return 00H.
- R6: The status byte holds the picture-change flag in bit 4, `ident_i` in bits 3:1 and the supply flag in bit 0. Bits 7:5 read 0.
- R7: A one-cycle pulse on `pic_change_i` or `supply_fail_i` sets its flag. The flag stays set until the status byte is read. It clears at the acknowledge clock (ACK or NACK) that ends the status byte.
- R8: An event that arrives after the status byte was loaded for sending, and before its acknowledge clock, leaves its flag set after that read.
- R9: After a picture change, `change_n_o` goes low one cycle after the next rising edge of `retrace_line_i`. It stays low for as many cycles as that line lasts, and is high at all other times, including later lines with no new change.
- R10: After the host NACKs a read byte, the block releases SDA until the next START, so further clocking reads FFH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_drive_low_o | output | 1 | 1 requests the open-drain pad to pull SDA low |
| addr_sel_i | input | 1 | Address select pin |
| pic_change_i | input | 1 | One-cycle pulse on a significant picture change |
| supply_fail_i | input | 1 | One-cycle pulse on a supply interruption |
| ident_i | input | 3 | Identification code placed in the status byte |
| meas_flat_i | input | 32 | Four read-only measurement bytes |
| retrace_line_i | input | 1 | High for the duration of the chosen retrace line |
| ctl_flat_o | output | 88 | Eleven control registers, register n in bits 8n+7:8n |
| change_n_o | output | 1 | Active-low picture-change indicator |

## Verification
SCL and SDA pass through two synchronizer flops and one edge-compare flop. Every reaction to a bus edge therefore shows up about three clocks after that edge: the acknowledge drive, the next read bit, a register write and a flag clear. The bench holds each SCL phase for eight clocks and samples SDA in the middle of the SCL-high phase. Register contents and flags are checked only after the STOP, when every update has settled. The indicator pin answers one cycle after `retrace_line_i` rises, so the bench counts its low cycles at falling clock edges over a window wider than the line.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_SUB, ST_WR, ST_RD, ST_WAIT
  } i2c_st_e;

  // Address pin mirrored into two positions of the 7-bit address
  function automatic logic [6:0] slave_addr(input logic sel);
    return {sel, 1'b1, sel, 4'b0000};
  endfunction

  // Power-on values: gain-mode bit in reg 0, gamma midpoint in reg 6
  function automatic logic [BYTE_W-1:0] ctl_reset_val(input int idx);
    if (idx == 0) return 8'h01;
    if (idx == 6) return 8'h20;
    return 8'h00;
  endfunction

  function automatic logic [BYTE_W-1:0] status_pack(input logic cf,
                                                     input logic [2:0] id,
                                                     input logic pdd);
    return {3'b000, cf, id, pdd};
  endfunction
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [2:0] scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  assign sda_s     = sda_p[1];
  assign scl_rise  = scl_p[1] & ~scl_p[2];
  assign scl_fall  = ~scl_p[1] & scl_p[2];
  assign start_det = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  assign stop_det  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
endmodule

// File: rtl/i2c_frame_fsm.sv
module i2c_frame_fsm
  import vidctl_pkg::*;
#(
  parameter int NUM_CTL = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_det,
  input  logic        stop_det,
  input  logic        sda_s,
  input  logic        addr_sel,
  input  logic [7:0]  tx_byte,
  output logic [7:0]  tx_idx,
  output logic        tx_load,
  output logic        tx_acked,
  output logic [7:0]  rd_ptr,
  output logic        wr_en,
  output logic [7:0]  wr_idx,
  output logic [7:0]  wr_data,
  output logic        sda_low
);
  localparam logic [7:0] LAST_CTL = 8'(NUM_CTL - 1);

  i2c_st_e    state;
  logic [3:0] cnt;
  logic [6:0] shreg;
  logic [7:0] txreg, ptr, rptr;
  logic       ack_en, rw, mack;

  logic [7:0] byte_in;
  logic       active, byte_end, ack_rise, frame_end, rd_start, rd_next;
  logic [2:0] bit_sel;

  assign byte_in   = {shreg, sda_s};
  assign active    = (state == ST_ADDR) || (state == ST_SUB) ||
                     (state == ST_WR) || (state == ST_RD);
  assign byte_end  = active && scl_rise && (cnt == 4'd7);
  assign ack_rise  = active && scl_rise && (cnt == 4'd8);
  assign frame_end = active && scl_fall && (cnt == 4'd9);
  assign rd_start  = frame_end && (state == ST_ADDR) && ack_en && rw;
  assign rd_next   = frame_end && (state == ST_RD) && mack;
  assign bit_sel   = 3'(4'd7 - cnt);

  assign tx_load  = rd_start | rd_next;
  assign tx_idx   = rd_start ? 8'h00 : ((rptr == 8'hFF) ? 8'hFF : rptr + 8'd1);
  assign tx_acked = ack_rise && (state == ST_RD);
  assign rd_ptr   = rptr;
  assign wr_en    = byte_end && (state == ST_WR) && (ptr <= LAST_CTL);
  assign wr_idx   = ptr;
  assign wr_data  = byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; cnt <= '0; shreg <= '0; txreg <= '0;
      ptr <= '0; rptr <= '0; ack_en <= 1'b0; rw <= 1'b0;
      mack <= 1'b0; sda_low <= 1'b0;
    end else if (start_det) begin
      state <= ST_ADDR; cnt <= '0; sda_low <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE; sda_low <= 1'b0;
    end else if (active && scl_rise) begin
      cnt   <= cnt + 4'd1;
      shreg <= byte_in[6:0];
      if (byte_end) begin
        case (state)
          ST_ADDR: begin
            ack_en <= (byte_in[7:1] == slave_addr(addr_sel));
            rw     <= byte_in[0];
          end
          ST_SUB:  begin ptr <= byte_in; ack_en <= 1'b1; end
          ST_WR:   ack_en <= 1'b1;
          default: ack_en <= 1'b0;
        endcase
      end
      if (ack_rise) mack <= ~sda_s;
    end else if (active && scl_fall) begin
      if (cnt == 4'd8) begin
        sda_low <= (state == ST_RD) ? 1'b0 : ack_en;
      end else if (cnt == 4'd9) begin
        cnt     <= '0;
        sda_low <= 1'b0;
        case (state)
          ST_ADDR: begin
            if (!ack_en) state <= ST_WAIT;
            else if (rw) begin
              state <= ST_RD; rptr <= 8'h00;
              txreg <= tx_byte; sda_low <= ~tx_byte[7];
            end else state <= ST_SUB;
          end
          ST_SUB: state <= ST_WR;
          ST_WR:  if (ptr != 8'hFF) ptr <= ptr + 8'd1;
          ST_RD: begin
            if (mack) begin
              rptr <= tx_idx; txreg <= tx_byte; sda_low <= ~tx_byte[7];
            end else state <= ST_WAIT;
          end
          default: state <= ST_WAIT;
        endcase
      end else if (state == ST_RD) begin
        sda_low <= ~txreg[bit_sel];
      end
    end
  end

  // R1: outside a live frame the data line is never pulled
  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) || (state == ST_WAIT)) |-> !sda_low);
  // R3: frame counter never passes the acknowledge clock
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd9);
  // R5: a read frame always opens on the status byte
  assert_rd_from_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RD) && ($past(state) != ST_RD)) |-> (rptr == 8'h00));
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import vidctl_pkg::*;
#(
  parameter int NUM_CTL = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_idx,
  input  logic [7:0]                 wr_data,
  output logic [NUM_CTL*BYTE_W-1:0]  ctl_flat
);
  for (genvar i = 0; i < NUM_CTL; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_flat[i*BYTE_W +: BYTE_W] <= ctl_reset_val(i);
      else if (wr_en && (wr_idx == 8'(i))) ctl_flat[i*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  // R4: the frame engine never issues a write outside the register range
  assert_wr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < 8'(NUM_CTL)));
endmodule

// File: rtl/status_flags.sv
module status_flags
  import vidctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chg_ev,
  input  logic       pwr_ev,
  input  logic [2:0] ident,
  input  logic       snap_load,
  input  logic       snap_clr,
  input  logic       retrace_line,
  output logic [7:0] status_byte,
  output logic       change_n
);
  logic cf, pdd, late_cf, late_pd;
  logic pend, showing, rl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf <= 1'b0; pdd <= 1'b0; late_cf <= 1'b0; late_pd <= 1'b0;
    end else begin
      late_cf <= snap_load ? chg_ev : (late_cf | chg_ev);
      late_pd <= snap_load ? pwr_ev : (late_pd | pwr_ev);
      cf  <= snap_clr ? (late_cf | chg_ev) : (cf | chg_ev);
      pdd <= snap_clr ? (late_pd | pwr_ev) : (pdd | pwr_ev);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; showing <= 1'b0; rl_q <= 1'b0;
    end else begin
      rl_q <= retrace_line;
      if (retrace_line && !rl_q) begin
        showing <= pend;
        pend    <= chg_ev;
      end else begin
        if (!retrace_line && rl_q) showing <= 1'b0;
        if (chg_ev) pend <= 1'b1;
      end
    end
  end

  assign status_byte = status_pack(cf, ident, pdd);
  assign change_n    = ~showing;

  // R7: an event always leaves its flag set on the next cycle
  assert_ev_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chg_ev |=> cf);
  // R7: a read with no fresh event clears the change flag
  assert_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_clr && !chg_ev && !late_cf) |=> !cf);
  // R9: the indicator is only low inside a retrace line
  assert_pin_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !change_n |-> $past(retrace_line));
endmodule

// File: rtl/vidctl_i2c_regs.sv
module vidctl_i2c_regs
  import vidctl_pkg::*;
#(
  parameter int NUM_CTL  = 11,
  parameter int NUM_MEAS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_drive_low_o,
  input  logic                       addr_sel_i,
  input  logic                       pic_change_i,
  input  logic                       supply_fail_i,
  input  logic [2:0]                 ident_i,
  input  logic [NUM_MEAS*BYTE_W-1:0] meas_flat_i,
  input  logic                       retrace_line_i,
  output logic [NUM_CTL*BYTE_W-1:0]  ctl_flat_o,
  output logic                       change_n_o
);
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] tx_byte, tx_idx, rd_ptr, wr_idx, wr_data, status_byte;
  logic       tx_load, tx_acked, wr_en;
  logic       snap_load, snap_clr;

  i2c_line_sampler u_samp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2c_frame_fsm #(.NUM_CTL(NUM_CTL)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .addr_sel(addr_sel_i), .tx_byte(tx_byte), .tx_idx(tx_idx),
    .tx_load(tx_load), .tx_acked(tx_acked), .rd_ptr(rd_ptr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sda_low(sda_drive_low_o));

  ctl_regfile #(.NUM_CTL(NUM_CTL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .ctl_flat(ctl_flat_o));

  assign snap_load = tx_load && (tx_idx == 8'h00);
  assign snap_clr  = tx_acked && (rd_ptr == 8'h00);

  status_flags u_stat (
    .clk(clk), .rst_n(rst_n), .chg_ev(pic_change_i), .pwr_ev(supply_fail_i),
    .ident(ident_i), .snap_load(snap_load), .snap_clr(snap_clr),
    .retrace_line(retrace_line_i), .status_byte(status_byte),
    .change_n(change_n_o));

  always_comb begin
    tx_byte = 8'h00;
    if (tx_idx == 8'h00) tx_byte = status_byte;
    for (int k = 1; k <= NUM_MEAS; k++)
      if (tx_idx == 8'(k)) tx_byte = meas_flat_i[(k-1)*BYTE_W +: BYTE_W];
  end
endmodule

// File: tb/vidctl_i2c_regs_bench.sv
module vidctl_i2c_regs_bench;
  localparam int NCTL = 11;
  localparam int Q = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic addr_sel = 1'b0, pic_chg = 1'b0, pwr_fail = 1'b0, retr = 1'b0;
  logic [2:0] ident = 3'b101;
  logic [31:0] meas = 32'h44332211;
  logic sda_low, change_n;
  logic [NCTL*8-1:0] ctl;
  wire  sda_bus = sda_m & ~sda_low;

  int checks = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] model [NCTL];

  always #2 clk = ~clk;

  vidctl_i2c_regs u_vidctl_i2c_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_drive_low_o(sda_low), .addr_sel_i(addr_sel),
    .pic_change_i(pic_chg), .supply_fail_i(pwr_fail), .ident_i(ident),
    .meas_flat_i(meas), .retrace_line_i(retr), .ctl_flat_o(ctl),
    .change_n_o(change_n));

  // {subaddress, data}
  localparam logic [15:0] WR_VEC [8] = '{
    {8'h00, 8'h5A}, {8'h06, 8'h3F}, {8'h0A, 8'hC3}, {8'h03, 8'h81},
    {8'h0B, 8'hEE}, {8'h0C, 8'h11}, {8'h05, 8'h00}, {8'h01, 8'hFF}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); ack = ~sda_bus; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1'b1; wq(Q); b[i] = sda_bus; wq(Q); scl = 1'b0;
    end
    wq(Q); sda_m = ~mack; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q); sda_m = 1'b1;
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NCTL; i++) chk(req, ctl[i*8 +: 8], model[i]);
  endtask

  task automatic pulse(input bit which);
    if (which) pic_chg = 1'b1; else pwr_fail = 1'b1;
    wq(1); pic_chg = 1'b0; pwr_fail = 1'b0;
  endtask

  task automatic read_status(output logic [7:0] s);
    bit a;
    i2c_start(); send_byte(8'h41, a); recv_byte(1'b0, s); i2c_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    int lows;
    for (int i = 0; i < NCTL; i++) model[i] = 8'h00;
    model[0] = 8'h01; model[6] = 8'h20;
    wq(5); rst_n = 1'b1; wq(5);

    // R2 reset state
    chk_regs("R2 reset value");
    chk("R2 pin idle", {31'd0, change_n}, 32'd1);
    chk("R2 sda released", {31'd0, sda_low}, 32'd0);

    // R3/R4 vector table: single-byte writes
    foreach (WR_VEC[v]) begin
      logic [7:0] sa, dv;
      sa = WR_VEC[v][15:8]; dv = WR_VEC[v][7:0];
      i2c_start();
      send_byte(8'h40, a); chk("R1 address ack", {31'd0, a}, 32'd1);
      send_byte(sa, a);    chk("R3 subaddress ack", {31'd0, a}, 32'd1);
      send_byte(dv, a);    chk("R4 data ack", {31'd0, a}, 32'd1);
      i2c_stop();
      if (sa < 8'(NCTL)) model[sa] = dv;
      chk_regs(sa < 8'(NCTL) ? "R3 table write" : "R4 out of range ignored");
    end

    // R3/R4 burst crossing the top of the map
    i2c_start(); send_byte(8'h40, a); send_byte(8'h08, a);
    send_byte(8'hA8, a); send_byte(8'hA9, a); send_byte(8'hAA, a);
    send_byte(8'hAB, a); chk("R4 ack past end", {31'd0, a}, 32'd1);
    i2c_stop();
    model[8] = 8'hA8; model[9] = 8'hA9; model[10] = 8'hAA;
    chk_regs("R3 burst increment");

    // R1 wrong address
    i2c_start(); send_byte(8'h42, a); chk("R1 foreign nack", {31'd0, a}, 32'd0);
    send_byte(8'h00, a); i2c_stop();
    chk_regs("R1 foreign no write");

    // R1 pin high
    addr_sel = 1'b1;
    i2c_start(); send_byte(8'hE0, a); chk("R1 E0 ack", {31'd0, a}, 32'd1);
    send_byte(8'h02, a); send_byte(8'h77, a); i2c_stop();
    model[2] = 8'h77;
    i2c_start(); send_byte(8'h40, a); chk("R1 40 nack when sel high", {31'd0, a}, 32'd0);
    i2c_stop();
    chk_regs("R1 sel high write");
    addr_sel = 1'b0;

    // R5/R6/R7 full read
    pulse(1'b1); pulse(1'b0);
    i2c_start(); send_byte(8'h41, a);
    recv_byte(1'b1, b); chk("R6 status layout", {24'd0, b}, 32'h1B);
    recv_byte(1'b1, b); chk("R5 meas 1", {24'd0, b}, 32'h11);
    recv_byte(1'b1, b); chk("R5 meas 2", {24'd0, b}, 32'h22);
    recv_byte(1'b1, b); chk("R5 meas 3", {24'd0, b}, 32'h33);
    recv_byte(1'b1, b); chk("R5 meas 4", {24'd0, b}, 32'h44);
    recv_byte(1'b0, b); chk("R5 past end", {24'd0, b}, 32'h00);
    i2c_stop();
    read_status(b); chk("R7 cleared on read", {24'd0, b}, 32'h0A);

    // R8 event during status read
    i2c_start(); send_byte(8'h41, a); pulse(1'b1);
    recv_byte(1'b0, b); chk("R8 byte loaded before event", {24'd0, b}, 32'h0A);
    // R10 released after NACK
    recv_byte(1'b0, b); chk("R10 released after nack", {24'd0, b}, 32'hFF);
    i2c_stop();
    read_status(b); chk("R8 late event kept", {24'd0, b}, 32'h1A);
    read_status(b); chk("R7 cleared again", {24'd0, b}, 32'h0A);

    // R5 repeated start after a write
    i2c_start(); send_byte(8'h40, a); send_byte(8'h05, a);
    i2c_start(); send_byte(8'h41, a); chk("R5 rs addr ack", {31'd0, a}, 32'd1);
    recv_byte(1'b0, b); chk("R5 read restarts at status", {24'd0, b}, 32'h0A);
    i2c_stop();

    // R9 indicator pin
    chk("R9 high before event", {31'd0, change_n}, 32'd1);
    pulse(1'b1); wq(3);
    chk("R9 high outside line", {31'd0, change_n}, 32'd1);
    lows = 0; retr = 1'b1;
    for (int c = 0; c < 14; c++) begin
      if (c == 6) retr = 1'b0;
      wq(1); if (!change_n) lows++;
    end
    chk("R9 one line low", 32'(lows), 32'd6);
    lows = 0; retr = 1'b1;
    for (int c = 0; c < 14; c++) begin
      if (c == 6) retr = 1'b0;
      wq(1); if (!change_n) lows++;
    end
    chk("R9 no repeat", 32'(lows), 32'd0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule